// File: doc/BRIEF.md
# Mini UART Register Block

This block is the register face of a small UART. A 32-bit word-access register bus reads and writes a handful of registers. Underneath, a byte stream arrives on a valid/ready input and is held in a small circular receive FIFO. A CPU read of the data register takes the oldest byte and pops it. A CPU write to the data register launches the low byte on a transmit strobe that lasts one cycle.

The transmit side is treated as draining at once. Transmit status therefore always reports idle and empty, and a transmit interrupt is pending whenever it is enabled. Status and identify words are built from fixed constant bits plus the receive fill level. A single level interrupt output combines the receive and transmit causes.

Registers for baud rate, line control, modem control, modem status and scratch are kept only as addresses. They read as zero and ignore writes, as does every unmapped word. Bus reads are combinational in the cycle the select is high. Writes and pops take effect at the next rising edge.

Top module: `aux_uart_regs`

## Requirements
- R1: After reset the receive FIFO is empty, the interrupt-enable bits are 0, `irq` is 0, `rxReady` is 1 and `txStrobe` is 0.
- R2: A byte is stored when `rxValid` and `rxReady` are both high at a rising edge. Reads of the data word (byte offset 0x40) return stored bytes in arrival order in bits [7:0] with upper bits 0, and each such read removes one byte.
- R3: With 8 bytes held, `rxReady` is 0 and further input bytes are not stored. The count never exceeds 8.
- R4: A data read with the FIFO empty returns the byte at the current read position and changes neither that position nor the count.
- R5: A bus write to offset 0x40 drives `txStrobe` high for exactly the following cycle, with `txByte` equal to write bits [7:0].
- R6: A write to offset 0x44 keeps write bits [1:0] (bit 0 receive enable, bit 1 transmit enable). A read there returns 0xC0 ORed with those two bits.
- R7: `irq` is 1 when the transmit enable is set, or when the receive enable is set and the FIFO is non-empty, and is 0 otherwise. Offset 0x00 reads 1 when `irq` is 1, else 0.
- R8: Offset 0x48 reads 0xC0 ORed with a cause code and a flag. The cause code is 0x4 when the FIFO holds data and 0x2 otherwise. The flag is bit 0, set when `irq` is 0.
- R9: A write to offset 0x48 with bit 1 set empties the FIFO. A write there with bit 1 clear leaves the count unchanged.
- R10: Offset 0x54 reads 0x60, with bit 0 also set when the FIFO is non-empty.
- R11: Offset 0x64 reads 0x30E. When the FIFO is non-empty, bit 0 is also set and the count appears in bits [19:16].
- R12: Offset 0x04 reads 1 and offset 0x60 reads 3, and writes to them change nothing. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unmapped word read 0 and ignore writes.
- R13: An input byte and a data-register pop in the same cycle both take effect, leaving the count unchanged. During a cycle that writes the flush bit, `rxReady` is 0, so no byte enters that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address; bits [1:0] ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWrite is low, else 0 |
| rxValid | input | 1 | Incoming byte present |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | Receive FIFO can take a byte this cycle |
| txStrobe | output | 1 | One-cycle pulse per transmitted byte |
| txByte | output | 8 | Byte to transmit, valid with txStrobe |
| irq | output | 1 | Level interrupt |

## Verification
The byte stream and the CPU act on the FIFO independently, so an arriving byte can meet a data-register pop or a flush write in the same cycle. The bench raises `rxValid` in the same cycle as a data read when three bytes are queued. The read must return the oldest byte, and the extended status count must still read 3 afterwards. The bench also holds `rxValid` through a flush write. In that cycle `rxReady` must be low, and the count must be zero after the edge, with no stray byte left behind.

// File: rtl/aux_uart_pkg.sv
`timescale 1ns/1ps
package aux_uart_pkg;

  localparam int ADDR_W = 8;
  localparam int IDX_W  = ADDR_W - 2;

  // Word indices (byte offset / 4) of the decoded registers
  localparam logic [IDX_W-1:0] IDX_IRQ_STAT = IDX_W'(6'h00);
  localparam logic [IDX_W-1:0] IDX_ENABLES  = IDX_W'(6'h01);
  localparam logic [IDX_W-1:0] IDX_DATA     = IDX_W'(6'h10);
  localparam logic [IDX_W-1:0] IDX_INT_EN   = IDX_W'(6'h11);
  localparam logic [IDX_W-1:0] IDX_INT_ID   = IDX_W'(6'h12);
  localparam logic [IDX_W-1:0] IDX_LINE_ST  = IDX_W'(6'h15);
  localparam logic [IDX_W-1:0] IDX_CONTROL  = IDX_W'(6'h18);
  localparam logic [IDX_W-1:0] IDX_EXT_ST   = IDX_W'(6'h19);

  // Fixed read patterns
  localparam logic [31:0] FIFO_FLAGS   = 32'h0000_00C0;
  localparam logic [31:0] LINE_IDLE    = 32'h0000_0060;
  localparam logic [31:0] EXT_IDLE     = 32'h0000_030E;
  localparam logic [31:0] ENABLES_VAL  = 32'h0000_0001;
  localparam logic [31:0] CONTROL_VAL  = 32'h0000_0003;
  localparam int          EXT_CNT_LSB  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;    // store incoming byte
    logic pop;     // advance read position
    logic flush;   // force count to zero
    logic txLoad;  // launch transmit byte
  } fifoStrobe_t;

endpackage

// File: rtl/aux_uart_dp.sv
`timescale 1ns/1ps
module aux_uart_dp
  import aux_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] wrByte,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] headByte,
  output logic              txStrobe,
  output logic [DATA_W-1:0] txByte
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic [SUM_W-1:0]  slotSum;
  logic [SUM_W-1:0]  slotWrap;

  // write slot = read position + count, folded into the ring
  always_comb begin
    slotSum  = SUM_W'(rdPtr) + SUM_W'(count);
    slotWrap = (slotSum >= DEPTH_S) ? (slotSum - DEPTH_S) : slotSum;
    wrPtr    = slotWrap[PTR_W-1:0];
  end

  assign headByte = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.push) begin
      mem[wrPtr] <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (stb.pop) begin
      rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.flush) begin
      count <= '0;
    end else begin
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStrobe <= 1'b0;
      txByte   <= '0;
    end else begin
      txStrobe <= stb.txLoad;
      if (stb.txLoad) txByte <= wrByte;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (count == '0));

  a_r13_push_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.pop && !stb.flush) |=> (count == $past(count)));

  a_r5_tx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |=> (txStrobe && txByte == $past(wrByte)));

  a_r5_tx_single: assert property (@(posedge clk) disable iff (!rstN)
    !stb.txLoad |=> !txStrobe);

endmodule

// File: rtl/aux_uart_ctrl.sv
`timescale 1ns/1ps
module aux_uart_ctrl
  import aux_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] headByte,
  output fifoStrobe_t       stb,
  output logic              irq
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [IDX_W-1:0] wordIdx;
  logic             rdAcc;
  logic             wrAcc;
  logic [1:0]       intEn;
  logic             nonEmpty;
  logic             unusedBits;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign rdAcc      = busSel && !busWrite;
  assign wrAcc      = busSel && busWrite;
  assign nonEmpty   = (count != '0);
  assign unusedBits = ^{busAddr[1:0], busWdata[31:DATA_W]};

  // strobes toward the datapath
  always_comb begin
    stb.flush  = wrAcc && (wordIdx == IDX_INT_ID) && busWdata[1];
    stb.txLoad = wrAcc && (wordIdx == IDX_DATA);
    stb.pop    = rdAcc && (wordIdx == IDX_DATA) && nonEmpty;
    rxReady    = (count != FULL_C) && !stb.flush;
    stb.push   = rxValid && rxReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 2'b00;
    end else if (wrAcc && wordIdx == IDX_INT_EN) begin
      intEn <= busWdata[1:0];
    end
  end

  assign irq = (intEn[0] && nonEmpty) || intEn[1];

  // read mux
  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      case (wordIdx)
        IDX_IRQ_STAT: busRdata = {31'd0, irq};
        IDX_ENABLES:  busRdata = ENABLES_VAL;
        IDX_DATA:     busRdata = 32'(headByte);
        IDX_INT_EN:   busRdata = FIFO_FLAGS | {30'd0, intEn};
        IDX_INT_ID:   busRdata = FIFO_FLAGS
                                 | (nonEmpty ? 32'h4 : 32'h2)
                                 | {31'd0, !irq};
        IDX_LINE_ST:  busRdata = LINE_IDLE | {31'd0, nonEmpty};
        IDX_CONTROL:  busRdata = CONTROL_VAL;
        IDX_EXT_ST:   busRdata = nonEmpty
                                 ? (EXT_IDLE | 32'h1 | (32'(count) << EXT_CNT_LSB))
                                 : EXT_IDLE;
        default:      busRdata = '0;
      endcase
    end
  end

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_C) |-> !stb.push);

  a_r7_tx_irq: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && wordIdx == IDX_INT_EN && busWdata[1]) |=> irq);

  a_r4_empty_read_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && wordIdx == IDX_DATA && !nonEmpty && !rxValid) |=> $stable(count));

  a_r13_flush_no_push: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |-> !stb.push);

endmodule

// File: rtl/aux_uart_regs.sv
`timescale 1ns/1ps
module aux_uart_regs
  import aux_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txStrobe,
  output logic [DATA_W-1:0] txByte,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobe_t       stb;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] headByte;

  aux_uart_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rxValid  (rxValid),
    .rxReady  (rxReady),
    .count    (count),
    .headByte (headByte),
    .stb      (stb),
    .irq      (irq)
  );

  aux_uart_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxData   (rxData),
    .wrByte   (busWdata[DATA_W-1:0]),
    .count    (count),
    .headByte (headByte),
    .txStrobe (txStrobe),
    .txByte   (txByte)
  );

endmodule

// File: tb/aux_uart_regs_tb.sv
`timescale 1ns/1ps
module aux_uart_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;
  logic        txStrobe;
  logic [7:0]  txByte;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  aux_uart_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txStrobe(txStrobe), .txByte(txByte), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(posedge clk);
    #1 rxValid = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rxReady", {31'd0, rxReady}, 32'd1);
    chk("R1 txStrobe", {31'd0, txStrobe}, 32'd0);
    rdChk("R1 ext status empty", 8'h64, 32'h30E);
    rdChk("R1 int enable zero", 8'h44, 32'hC0);
  endtask

  task automatic t_constants;
    wr(8'h04, 32'h0);
    wr(8'h60, 32'hFF);
    wr(8'h5C, 32'hA5A5);
    wr(8'h68, 32'h1234);
    wr(8'h4C, 32'hFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rdChk("R12 enables", 8'h04, 32'h1);
    rdChk("R12 control", 8'h60, 32'h3);
    rdChk("R12 scratch", 8'h5C, 32'h0);
    rdChk("R12 baud", 8'h68, 32'h0);
    rdChk("R12 line ctrl", 8'h4C, 32'h0);
    rdChk("R12 modem ctrl", 8'h50, 32'h0);
    rdChk("R12 modem stat", 8'h58, 32'h0);
    rdChk("R12 unmapped", 8'h80, 32'h0);
    rdChk("R12 no irq side effect", 8'h00, 32'h0);
  endtask

  task automatic t_order;
    push(8'h11); push(8'h22); push(8'h33);
    rdChk("R10 line status data", 8'h54, 32'h61);
    rdChk("R11 ext status count3", 8'h64, 32'h3030F);
    rdChk("R8 identify rx no irq", 8'h48, 32'hC5);
    rdChk("R2 first", 8'h40, 32'h11);
    rdChk("R2 second", 8'h40, 32'h22);
    rdChk("R2 third", 8'h40, 32'h33);
    rdChk("R10 line status empty", 8'h54, 32'h60);
  endtask

  task automatic t_irq;
    wr(8'h44, 32'hFF);
    rdChk("R6 int enable masked", 8'h44, 32'hC3);
    #1 chk("R7 tx irq", {31'd0, irq}, 32'd1);
    rdChk("R8 identify tx", 8'h48, 32'hC2);
    rdChk("R7 global status", 8'h00, 32'h1);
    wr(8'h44, 32'h1);
    #1 chk("R7 rx only empty", {31'd0, irq}, 32'd0);
    push(8'h5A);
    #1 chk("R7 rx data irq", {31'd0, irq}, 32'd1);
    rdChk("R8 identify rx", 8'h48, 32'hC4);
    rdChk("R2 irq byte", 8'h40, 32'h5A);
    #1 chk("R7 rx drained", {31'd0, irq}, 32'd0);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_tx;
    wr(8'h40, 32'hFFFF_FF9C);
    chk("R5 strobe high", {31'd0, txStrobe}, 32'd1);
    chk("R5 byte", {24'd0, txByte}, 32'h9C);
    @(posedge clk); #1;
    chk("R5 strobe single", {31'd0, txStrobe}, 32'd0);
    rdChk("R5 no rx effect", 8'h64, 32'h30E);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    #1 chk("R3 ready low", {31'd0, rxReady}, 32'd0);
    rdChk("R11 ext status full", 8'h64, 32'h8030F);
    push(8'hEE);
    rdChk("R3 extra dropped", 8'h64, 32'h8030F);
    for (int i = 0; i < 8; i++) rdChk("R3 full drain", 8'h40, 32'hA0 + i);
    rdChk("R4 empty read", 8'h40, 32'hA0);
    rdChk("R4 empty read again", 8'h40, 32'hA0);
    rdChk("R4 count unchanged", 8'h64, 32'h30E);
  endtask

  task automatic t_flush;
    push(8'h01); push(8'h02);
    wr(8'h48, 32'h1);
    rdChk("R9 no flush bit", 8'h64, 32'h2030F);
    wr(8'h48, 32'h2);
    rdChk("R9 flushed", 8'h64, 32'h30E);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    push(8'hC1); push(8'hC2); push(8'hC3);
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hC4;
    busSel = 1'b1; busWrite = 1'b0; busAddr = 8'h40;
    #1 d = busRdata;
    @(posedge clk);
    #1 rxValid = 1'b0; busSel = 1'b0;
    chk("R13 pop oldest", d, 32'hC1);
    rdChk("R13 count kept", 8'h64, 32'h3030F);
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hEE;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h48; busWdata = 32'h2;
    #1 chk("R13 ready low on flush", {31'd0, rxReady}, 32'd0);
    @(posedge clk);
    #1 rxValid = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    rdChk("R13 flush wins", 8'h64, 32'h30E);
    push(8'hD1);
    rdChk("R13 fresh byte", 8'h40, 32'hD1);
  endtask

  initial begin
    #(5.0 * 100000);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset;
    t_constants;
    t_order;
    t_irq;
    t_tx;
    t_full;
    t_flush;
    t_same_cycle;
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule